// File: doc/BRIEF.md
# Buffered Pulse-Width Modulator Channel

This block produces a single pulse-width modulated output from a free-running tick enable. Software programs a period register and a high-time register through a small write port (write strobe, address, data). Both values are first held in pending copies. They reach the counting logic only at a period boundary, so a change made in the middle of a period never distorts the waveform already in progress.

By default each pending value moves to the active copy at every boundary, on its own. As a result, two writes that straddle a boundary produce exactly one mixed period. If the hold bit is set, pending values stay parked until an update strobe arms a transfer. Both values then switch together at the next boundary. Clearing the enable bit silences the output at once rather than at the end of the period. Setting it again restarts the period from zero with the pending values. A one-cycle wrap pulse marks the start of each new period.

Top module: `pwm_buffered`

## Requirements
- R1: With active period value P, a period lasts exactly P+1 tick-enabled cycles, and the count advances only in cycles where `tick` is high.
- R2: Within a period the output is high while the count (0 to P) is below the active high-time value H, so H = 0 keeps the output low for the whole period.
- R3: When H is greater than P, the output stays high for the entire period (full duty).
- R4: With hold clear, a period or high-time write made during a period leaves that period unchanged and applies from the next boundary. Each register transfers independently, so a period write before a boundary and a high-time write after it give one period with the new period and the old high time.
- R5: With hold set, pending values are not applied at boundaries until `upd` is pulsed. Both are then applied together at the next boundary.
- R6: Writing the control register with enable = 0 forces the output low in the cycle after the write, even in the middle of a period.
- R7: Pulsing `upd` while the channel is disabled leaves the output low, and no wrap pulse appears.
- R8: Writing enable = 1 to a disabled channel restarts the count at 0 in the next cycle, with the pending period and high time already active.
- R9: `wrap_pulse` is high for exactly one cycle: the first cycle of every period that follows a completed one.
- R10: Register addresses are 0 for control (bit 0 enable, bit 1 hold), 1 for period and 2 for high time. After reset all registers are zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable; the count advances only when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 period, 2 high time |
| wr_data | input | 16 | Write data |
| upd | input | 1 | Update strobe that arms a joint transfer in hold mode |
| pwm_out | output | 1 | Modulated output |
| wrap_pulse | output | 1 | One-cycle marker at the start of each new period |

## Verification
All state sits in registers and the output is decoded from them. Every effect of a write, a strobe or a boundary edge is therefore visible one cycle after the clock edge that captures it. The bench drives inputs and samples outputs one time unit after each rising edge, and it tracks the position in the period by counting edges from the enabling write. The sweep over small period and high-time values checks each cycle of two whole periods against the arithmetic expectation. The mid-period, straddling, hold, disable and restart cases check the cycle just before and just after each boundary, where an early or late transfer would show.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int VAL_W  = 16;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_RANGE = 2'd1,
        REG_DUTY  = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic [VAL_W-1:0] range;
        logic [VAL_W-1:0] duty;
    } pwm_cfg_t;

    typedef struct packed {
        logic hold;
        logic enable;
    } pwm_ctrl_t;

    function automatic logic sel_is(input logic [ADDR_W-1:0] a, input reg_sel_e s);
        return a == s;
    endfunction
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [VAL_W-1:0]  wr_data,
    input  logic              upd,
    input  logic              boundary,
    output pwm_ctrl_t         ctrl,
    output pwm_cfg_t          act,
    output logic              restart
);
    pwm_cfg_t pend;
    logic     armed;
    logic     ctrl_wr;
    logic     load;

    assign ctrl_wr = wr_en && sel_is(wr_addr, REG_CTRL);
    assign restart = ctrl_wr && wr_data[0] && !ctrl.enable;
    assign load    = restart || (boundary && (!ctrl.hold || armed));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            act   <= '0;
            ctrl  <= '0;
            armed <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl.enable <= wr_data[0];
                ctrl.hold   <= wr_data[1];
            end
            if (wr_en && sel_is(wr_addr, REG_RANGE)) pend.range <= wr_data;
            if (wr_en && sel_is(wr_addr, REG_DUTY))  pend.duty  <= wr_data;
            if (load) begin
                act   <= pend;
                armed <= upd;
            end else if (upd) begin
                armed <= 1'b1;
            end
        end
    end

    // R4: active values only move at a boundary or a restart
    a_r4_active_stable: assert property (@(posedge clk) disable iff (rst)
        (ctrl.enable && !boundary) |=> $stable(act));

    // R5: in hold mode nothing moves until the strobe has armed a transfer
    a_r5_hold_parks: assert property (@(posedge clk) disable iff (rst)
        (ctrl.hold && !armed && !restart) |=> $stable(act));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     en,
    input  logic     restart,
    input  pwm_cfg_t act,
    output logic     boundary,
    output logic     pwm_out,
    output logic     wrap_pulse
);
    logic [VAL_W-1:0] cnt;

    assign boundary = en && tick && (cnt == act.range);
    assign pwm_out  = en && (cnt < act.duty);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            wrap_pulse <= 1'b0;
        end else begin
            wrap_pulse <= boundary;
            if (!en || restart || boundary) cnt <= '0;
            else if (tick)                  cnt <= cnt + 1'b1;
        end
    end

    // R1: the count never passes the active period value
    a_r1_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt <= act.range));

    // R1: no tick, no advance
    a_r1_tick_gates: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(cnt));

    // R3: a high time above the period keeps the output high
    a_r3_full_duty: assert property (@(posedge clk) disable iff (rst)
        (en && (act.duty > act.range)) |-> pwm_out);

    // R9: the wrap marker always sits on the first count of a period
    a_r9_wrap_at_zero: assert property (@(posedge clk) disable iff (rst)
        wrap_pulse |-> (cnt == '0));
endmodule

// File: rtl/pwm_buffered.sv
module pwm_buffered
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [VAL_W-1:0]  wr_data,
    input  logic              upd,
    output logic              pwm_out,
    output logic              wrap_pulse
);
    pwm_ctrl_t ctrl;
    pwm_cfg_t  act;
    logic      restart;
    logic      boundary;

    pwm_cfg_regs i_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .upd      (upd),
        .boundary (boundary),
        .ctrl     (ctrl),
        .act      (act),
        .restart  (restart)
    );

    pwm_counter i_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .en         (ctrl.enable),
        .restart    (restart),
        .act        (act),
        .boundary   (boundary),
        .pwm_out    (pwm_out),
        .wrap_pulse (wrap_pulse)
    );

    // R6: a disabling write silences the output on the next cycle
    a_r6_disable_cuts: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == REG_CTRL) && !wr_data[0]) |=> !pwm_out);
endmodule

// File: tb/test_pwm_buffered.sv
module test_pwm_buffered;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        upd = 1'b0;
    logic        pwm_out;
    logic        wrap_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_buffered i_pwm_buffered (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .upd(upd), .pwm_out(pwm_out), .wrap_pulse(wrap_pulse)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic setup(input int r, input int d, input logic [1:0] c);
        wr(0, 0); wr(1, 16'(r)); wr(2, 16'(d)); wr(0, 16'(c));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
            $finish;
        end
    end

    initial begin
        int wraps;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R10: reset state
        chk("R10 reset out", pwm_out, 1'b0);
        chk("R10 reset wrap", wrap_pulse, 1'b0);

        // R1 R2 R3 R8 R9: sweep small period and high-time values
        for (int r = 0; r <= 5; r++) begin
            for (int d = 0; d <= 7; d++) begin
                setup(r, d, 2'b01);
                for (int i = 0; i < 2; i++) begin
                    for (int j = 0; j <= r; j++) begin
                        chk(d > r ? "R3 full" : "R2 compare", pwm_out, logic'(j < d));
                        chk("R9 R1 wrap", wrap_pulse, logic'(i > 0 && j == 0));
                        step();
                    end
                end
            end
        end

        // R1: tick every other cycle, period value 3 -> 8 cycles per period
        setup(3, 2, 2'b01);
        wraps = 0;
        for (int k = 0; k < 40; k++) begin
            tick = (k % 2 == 0);
            step();
            if (wrap_pulse) wraps++;
        end
        tick = 1'b1;
        checks++;
        if (wraps != 5) begin
            fails++;
            $display("FAIL R1 tick gating: got %0d wraps expected 5", wraps);
        end

        // R4: mid-period high-time write waits for the boundary
        setup(7, 2, 2'b01);              // j=0
        repeat (3) step();               // j=3
        wr(2, 6);                        // j=4
        chk("R4 old duty kept", pwm_out, 1'b0);
        repeat (4) step();               // next period j=0
        chk("R4 new duty j0", pwm_out, 1'b1);
        repeat (4) step();               // j=4
        chk("R4 new duty j4", pwm_out, 1'b1);
        // R4: period written before the boundary, high time after it
        step();                          // j=5
        wr(1, 3);                        // j=6
        step();                          // j=7
        step();                          // j=0, period 3, high time 6
        wr(2, 1);                        // j=1
        chk("R4 mixed j1", pwm_out, 1'b1);
        step();                          // j=2
        chk("R4 mixed j2 old duty", pwm_out, 1'b1);
        step();                          // j=3
        step();                          // j=0 after a 4-cycle period
        chk("R4 new range wrap", wrap_pulse, 1'b1);
        chk("R4 new duty j0", pwm_out, 1'b1);
        step();                          // j=1
        chk("R4 new duty j1", pwm_out, 1'b0);

        // R5: hold mode parks pending values until the strobe
        setup(3, 1, 2'b11);              // j=0
        wr(2, 4);                        // j=1
        step();                          // j=2
        chk("R5 held j2", pwm_out, 1'b0);
        repeat (4) step();               // next period j=2
        chk("R5 still held", pwm_out, 1'b0);
        upd = 1'b1;
        step();                          // j=3
        upd = 1'b0;
        chk("R5 no early apply", pwm_out, 1'b0);
        step();                          // j=0
        step();                          // j=1
        step();                          // j=2
        chk("R5 applied", pwm_out, 1'b1);

        // R6: disable cuts output mid-period
        setup(9, 10, 2'b01);
        chk("R6 on before", pwm_out, 1'b1);
        repeat (3) step();
        wr(0, 0);
        chk("R6 cut", pwm_out, 1'b0);
        // R7: strobe while disabled keeps output low
        upd = 1'b1;
        step();
        upd = 1'b0;
        for (int k = 0; k < 12; k++) begin
            chk("R7 low", pwm_out, 1'b0);
            chk("R7 no wrap", wrap_pulse, 1'b0);
            step();
        end
        // R8: re-enable restarts with pending values
        wr(1, 2); wr(2, 1);
        wr(0, 1);                        // j=0
        chk("R8 j0", pwm_out, 1'b1);
        chk("R8 no wrap", wrap_pulse, 1'b0);
        step();
        chk("R8 j1", pwm_out, 1'b0);
        step();
        step();
        chk("R8 R9 wrap", wrap_pulse, 1'b1);
        step();
        chk("R9 single cycle", wrap_pulse, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule